// File: doc/BRIEF.md
# Nibble Data Memory with File/Digit Addressing

This block is the data store of a small 4-bit controller. It holds ten files of sixteen 4-bit digits, 160 digits in all. A normal access picks its digit from a file number and a digit number, which the instruction decoder supplies from its index registers. A second path goes straight to sixteen memory-register digits by a 4-bit index and needs no file or digit number. Only the exchange with the accumulator uses this second path.

Each request is a one-cycle strobe with a 3-bit operation code. The operations are:

- read a digit;
- write the accumulator into a digit;
- swap a digit with the accumulator, through either addressing path;
- set, clear or test one bit of a digit.

The memory array has a registered read port, so every operation is a read-modify-write over two clock edges. If a request follows a write to the same digit in the next cycle, it is forwarded the written value. When an operation both reads and writes, its result always shows the digit as it was before the write.

Top module: `nibble_ram`

## Requirements
- R1: While reset is high and after it is released with no request, resp_valid, rd_data, acc_out, addr_err and status_flag are all 0.
- R2: The operation codes are 0 nop, 1 read, 2 write, 3 register exchange, 4 bit set, 5 bit clear, 6 bit test and 7 indexed exchange. A request sampled at edge E gives resp_valid=1 for one cycle after edge E+1, with the response outputs valid in that cycle. A write stores acc_in at linear address x_file*16+y_digit, and a later read returns it on rd_data. Write and nop return rd_data=0.
- R3: Every operation except nop and register exchange is ignored when x_file is 10 or more. Memory is unchanged, rd_data=0, acc_out=acc_in, status_flag holds its value, and addr_err=1 for that response.
- R4: Register exchange ignores x_file and y_digit. Memory register k is the digit at file 9, digit k, so the indexed path reaches the same storage.
- R5: Both exchanges return the old digit on rd_data and acc_out and store acc_in. Every other operation returns acc_out=acc_in.
- R6: Bit set forces bit bit_sel of the addressed digit to 1; bit_sel 0 is the least significant bit. The other bits are kept, and rd_data shows the old digit.
- R7: Bit clear forces bit bit_sel to 0 and keeps the other bits. rd_data shows the old digit.
- R8: Bit test loads status_flag with bit bit_sel of the addressed digit. It leaves the memory unchanged and shows the digit on rd_data.
- R9: A request in the cycle right after a request that writes the same digit sees the value that request wrote.
- R10: status_flag changes only on an in-range bit test.
- R11: addr_err is cleared by the next response that is not out of range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_req | input | 1 | One-cycle operation strobe |
| op_kind | input | 3 | Operation code (see R2) |
| x_file | input | 4 | File number |
| y_digit | input | 4 | Digit number within the file |
| mr_idx | input | 4 | Memory-register index |
| bit_sel | input | 2 | Bit operand, 0 is the least significant bit |
| acc_in | input | 4 | Current accumulator value |
| resp_valid | output | 1 | Response strobe |
| rd_data | output | 4 | Old contents of the addressed digit |
| acc_out | output | 4 | New accumulator value |
| status_flag | output | 1 | Bit-test result |
| addr_err | output | 1 | Last response had an out-of-range file |

## Verification
The vector walk fills digits in several files, including file 9, and then reads them back. This separates a wrong linear address from a wrong memory-register mapping: a register exchange followed by an indexed read of file 9 catches either one. Bit set, clear and test are applied to each bit position against distinct values, which exposes a reversed or offset bit order. Reads placed after bit tests and after out-of-range requests show whether the flag or the memory was disturbed. Back-to-back requests to one digit show whether the second request sees stale data from the array rather than the forwarded value.

// File: rtl/nram_pkg.sv
package nram_pkg;
  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_READ   = 3'd1,
    OP_WRITE  = 3'd2,
    OP_XCH_MR = 3'd3,
    OP_BSET   = 3'd4,
    OP_BCLR   = 3'd5,
    OP_BTST   = 3'd6,
    OP_XCH_XY = 3'd7
  } nram_op_e;

  function automatic logic op_reads(nram_op_e k);
    return (k != OP_NOP) && (k != OP_WRITE);
  endfunction

  function automatic logic op_swaps(nram_op_e k);
    return (k == OP_XCH_MR) || (k == OP_XCH_XY);
  endfunction
endpackage

// File: rtl/nram_addr_map.sv
module nram_addr_map
  import nram_pkg::*;
#(
  parameter int FILES   = 10,
  parameter int DIGITS  = 16,
  parameter int XW      = 4,
  parameter int YW      = 4,
  parameter int AW      = 8,
  parameter int MR_FILE = 9
) (
  input  nram_op_e          kind,
  input  logic [XW-1:0]     x_file,
  input  logic [YW-1:0]     y_digit,
  input  logic [YW-1:0]     mr_idx,
  output logic [AW-1:0]     addr,
  output logic              in_range
);
  localparam logic [AW-1:0] MR_BASE = AW'(MR_FILE * DIGITS);

  logic [AW-1:0] lin_xy;
  logic          x_ok;

  assign x_ok   = int'(x_file) < FILES;
  assign lin_xy = AW'(x_file) * AW'(DIGITS) + AW'(y_digit);

  always_comb begin
    if (kind == OP_XCH_MR) begin
      addr     = MR_BASE + AW'(mr_idx);
      in_range = 1'b1;
    end else if (kind == OP_NOP) begin
      addr     = '0;
      in_range = 1'b1;
    end else begin
      addr     = x_ok ? lin_xy : '0;
      in_range = x_ok;
    end
  end
endmodule

// File: rtl/nram_store.sv
module nram_store #(
  parameter int DEPTH = 160,
  parameter int DW    = 4,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_q,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_q <= mem[rd_addr];
  end
endmodule

// File: rtl/nram_bitop.sv
module nram_bitop
  import nram_pkg::*;
#(
  parameter int DW = 4,
  parameter int BW = 2
) (
  input  nram_op_e      kind,
  input  logic [DW-1:0] old_digit,
  input  logic [BW-1:0] bit_sel,
  input  logic [DW-1:0] acc_in,
  output logic [DW-1:0] new_digit,
  output logic          wr_need,
  output logic          bit_val
);
  logic [DW-1:0] mask;

  assign mask    = DW'(1) << bit_sel;
  assign bit_val = |(old_digit & mask);

  always_comb begin
    new_digit = old_digit;
    wr_need   = 1'b0;
    unique case (kind)
      OP_WRITE, OP_XCH_MR, OP_XCH_XY: begin
        new_digit = acc_in;
        wr_need   = 1'b1;
      end
      OP_BSET: begin
        new_digit = old_digit | mask;
        wr_need   = 1'b1;
      end
      OP_BCLR: begin
        new_digit = old_digit & ~mask;
        wr_need   = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/nibble_ram.sv
module nibble_ram
  import nram_pkg::*;
#(
  parameter int FILES  = 10,
  parameter int DIGITS = 16,
  parameter int DW     = 4,
  parameter int XW     = 4,
  localparam int YW    = $clog2(DIGITS),
  localparam int BW    = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          op_req,
  input  logic [2:0]    op_kind,
  input  logic [XW-1:0] x_file,
  input  logic [YW-1:0] y_digit,
  input  logic [YW-1:0] mr_idx,
  input  logic [BW-1:0] bit_sel,
  input  logic [DW-1:0] acc_in,
  output logic          resp_valid,
  output logic [DW-1:0] rd_data,
  output logic [DW-1:0] acc_out,
  output logic          status_flag,
  output logic          addr_err
);
  localparam int DEPTH   = FILES * DIGITS;
  localparam int AW      = $clog2(DEPTH);
  localparam int MR_FILE = FILES - 1;

  nram_op_e      in_kind;
  logic [AW-1:0] in_addr;
  logic          in_ok;

  assign in_kind = nram_op_e'(op_kind);

  nram_addr_map #(
    .FILES(FILES), .DIGITS(DIGITS), .XW(XW), .YW(YW), .AW(AW), .MR_FILE(MR_FILE)
  ) u_map (
    .kind(in_kind), .x_file(x_file), .y_digit(y_digit), .mr_idx(mr_idx),
    .addr(in_addr), .in_range(in_ok)
  );

  // stage 1: request registered while the array is read
  logic          s1_valid;
  nram_op_e      s1_kind;
  logic [AW-1:0] s1_addr;
  logic          s1_ok;
  logic [BW-1:0] s1_bit;
  logic [DW-1:0] s1_acc;
  logic          s1_fwd_hit;
  logic [DW-1:0] s1_fwd_data;

  logic [DW-1:0] mem_q;
  logic [DW-1:0] cur_old;
  logic [DW-1:0] new_digit;
  logic          wr_need;
  logic          bit_val;
  logic          commit_we;

  assign cur_old   = s1_fwd_hit ? s1_fwd_data : mem_q;
  assign commit_we = s1_valid && s1_ok && wr_need;

  nram_bitop #(.DW(DW), .BW(BW)) u_bitop (
    .kind(s1_kind), .old_digit(cur_old), .bit_sel(s1_bit), .acc_in(s1_acc),
    .new_digit(new_digit), .wr_need(wr_need), .bit_val(bit_val)
  );

  nram_store #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_store (
    .clk(clk),
    .rd_en(op_req), .rd_addr(in_addr), .rd_q(mem_q),
    .wr_en(commit_we), .wr_addr(s1_addr), .wr_data(new_digit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid    <= 1'b0;
      s1_kind     <= OP_NOP;
      s1_addr     <= '0;
      s1_ok       <= 1'b0;
      s1_bit      <= '0;
      s1_acc      <= '0;
      s1_fwd_hit  <= 1'b0;
      s1_fwd_data <= '0;
    end else begin
      s1_valid    <= op_req;
      s1_kind     <= in_kind;
      s1_addr     <= in_addr;
      s1_ok       <= in_ok;
      s1_bit      <= bit_sel;
      s1_acc      <= acc_in;
      s1_fwd_hit  <= op_req && in_ok && commit_we && (in_addr == s1_addr);
      s1_fwd_data <= new_digit;
    end
  end

  // stage 2: registered response
  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid  <= 1'b0;
      rd_data     <= '0;
      acc_out     <= '0;
      status_flag <= 1'b0;
      addr_err    <= 1'b0;
    end else begin
      resp_valid <= s1_valid;
      if (s1_valid) begin
        rd_data  <= (s1_ok && op_reads(s1_kind)) ? cur_old : '0;
        acc_out  <= (s1_ok && op_swaps(s1_kind)) ? cur_old : s1_acc;
        addr_err <= !s1_ok;
        if (s1_ok && s1_kind == OP_BTST) status_flag <= bit_val;
      end
    end
  end
endmodule

// File: rtl/nram_chk.sv
module nram_chk #(
  parameter int FILES = 10,
  parameter int DW    = 4,
  parameter int XW    = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          op_req,
  input logic [2:0]    op_kind,
  input logic [XW-1:0] x_file,
  input logic [DW-1:0] acc_in,
  input logic          resp_valid,
  input logic [DW-1:0] rd_data,
  input logic [DW-1:0] acc_out,
  input logic          status_flag,
  input logic          addr_err
);
  logic uses_x, bad_x, is_swap, is_test;
  assign uses_x  = (op_kind != 3'd0) && (op_kind != 3'd3);
  assign bad_x   = uses_x && (int'(x_file) >= FILES);
  assign is_swap = (op_kind == 3'd3) || (op_kind == 3'd7);
  assign is_test = (op_kind == 3'd6);

  a_r2_resp_follows: assert property (@(posedge clk) disable iff (rst)
    op_req |=> ##1 resp_valid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
    (!op_req && !$past(op_req)) |=> !resp_valid);
  a_r3_out_of_range: assert property (@(posedge clk) disable iff (rst)
    (op_req && bad_x) |=> ##1 (addr_err && rd_data == '0));
  a_r11_err_clears: assert property (@(posedge clk) disable iff (rst)
    (op_req && !bad_x) |=> ##1 !addr_err);
  a_r10_flag_hold: assert property (@(posedge clk) disable iff (rst)
    !(op_req && is_test) |=> ##1 $stable(status_flag));
  a_r5_acc_pass: assert property (@(posedge clk) disable iff (rst)
    (op_req && !is_swap) |=> ##1 (acc_out == $past(acc_in, 2)));
endmodule

bind nibble_ram nram_chk #(.FILES(FILES), .DW(DW), .XW(XW)) u_chk (
  .clk(clk), .rst(rst), .op_req(op_req), .op_kind(op_kind), .x_file(x_file),
  .acc_in(acc_in), .resp_valid(resp_valid), .rd_data(rd_data), .acc_out(acc_out),
  .status_flag(status_flag), .addr_err(addr_err)
);

// File: tb/tb_nibble_ram.sv
module tb_nibble_ram;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       op_req = 1'b0;
  logic [2:0] op_kind = '0;
  logic [3:0] x_file = '0, y_digit = '0, mr_idx = '0, acc_in = '0;
  logic [1:0] bit_sel = '0;
  logic       resp_valid, status_flag, addr_err;
  logic [3:0] rd_data, acc_out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  nibble_ram dut (
    .clk(clk), .rst(rst), .op_req(op_req), .op_kind(op_kind), .x_file(x_file),
    .y_digit(y_digit), .mr_idx(mr_idx), .bit_sel(bit_sel), .acc_in(acc_in),
    .resp_valid(resp_valid), .rd_data(rd_data), .acc_out(acc_out),
    .status_flag(status_flag), .addr_err(addr_err)
  );

  task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkv(int k, int x, int y, int m, int n, int a,
                                      int erd, int eacc, int ef, int ee);
    return {1'b0, k[2:0], x[3:0], y[3:0], m[3:0], n[1:0], a[3:0],
            erd[3:0], eacc[3:0], ef[0], ee[0]};
  endfunction

  function automatic string req_of(logic [2:0] k);
    case (k)
      3'd3: return "R4 register exchange";
      3'd4: return "R6 bit set";
      3'd5: return "R7 bit clear";
      3'd6: return "R8 bit test";
      3'd7: return "R5 indexed exchange";
      default: return "R2 read/write";
    endcase
  endfunction

  localparam int NV = 23;
  //                     kind x   y  mr n  acc  rd  acc  flg err
  localparam logic [31:0] VECS [NV] = '{
    mkv(2, 0, 0, 0, 0, 5,   0, 5,   0, 0),
    mkv(2, 3, 7, 0, 0, 10,  0, 10,  0, 0),
    mkv(2, 9, 2, 0, 0, 6,   0, 6,   0, 0),
    mkv(1, 0, 0, 0, 0, 0,   5, 0,   0, 0),
    mkv(1, 3, 7, 0, 0, 0,   10, 0,  0, 0),
    mkv(3, 0, 0, 2, 0, 1,   6, 6,   0, 0),
    mkv(1, 9, 2, 0, 0, 0,   1, 0,   0, 0),
    mkv(7, 3, 7, 0, 0, 3,   10, 10, 0, 0),
    mkv(1, 3, 7, 0, 0, 0,   3, 0,   0, 0),
    mkv(4, 0, 0, 0, 1, 0,   5, 0,   0, 0),
    mkv(1, 0, 0, 0, 0, 0,   7, 0,   0, 0),
    mkv(5, 0, 0, 0, 0, 0,   7, 0,   0, 0),
    mkv(1, 0, 0, 0, 0, 0,   6, 0,   0, 0),
    mkv(6, 0, 0, 0, 3, 0,   6, 0,   0, 0),
    mkv(6, 0, 0, 0, 2, 0,   6, 0,   1, 0),
    mkv(1, 0, 0, 0, 0, 0,   6, 0,   1, 0),
    mkv(2, 10, 0, 0, 0, 15, 0, 15,  1, 1),
    mkv(6, 12, 0, 0, 0, 0,  0, 0,   1, 1),
    mkv(1, 0, 0, 0, 0, 0,   6, 0,   1, 0),
    mkv(3, 15, 0, 2, 0, 9,  1, 1,   1, 0),
    mkv(1, 9, 2, 0, 0, 0,   9, 0,   1, 0),
    mkv(5, 3, 7, 0, 1, 0,   3, 0,   1, 0),
    mkv(1, 3, 7, 0, 0, 0,   1, 0,   1, 0)
  };

  task automatic drive(logic [2:0] k, logic [3:0] x, logic [3:0] y, logic [3:0] m,
                       logic [1:0] n, logic [3:0] a);
    op_req = 1'b1; op_kind = k; x_file = x; y_digit = y; mr_idx = m;
    bit_sel = n; acc_in = a;
  endtask

  task automatic single(logic [2:0] k, logic [3:0] x, logic [3:0] y, logic [3:0] m,
                        logic [1:0] n, logic [3:0] a);
    @(negedge clk) drive(k, x, y, m, n, a);
    @(negedge clk) op_req = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 resp_valid in reset", {3'b0, resp_valid}, 4'h0);
    chk("R1 status_flag in reset", {3'b0, status_flag}, 4'h0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 rd_data after reset", rd_data, 4'h0);
    chk("R1 acc_out after reset", acc_out, 4'h0);
    chk("R1 addr_err after reset", {3'b0, addr_err}, 4'h0);
    chk("R1 idle resp_valid", {3'b0, resp_valid}, 4'h0);

    // vector walk
    for (int i = 0; i < NV; i++) begin
      logic [31:0] v;
      v = VECS[i];
      single(v[30:28], v[27:24], v[23:20], v[19:16], v[15:14], v[13:10]);
      chk("R2 resp_valid latency", {3'b0, resp_valid}, 4'h1);
      chk(req_of(v[30:28]), rd_data, v[9:6]);
      chk(req_of(v[30:28]), acc_out, v[5:2]);
      chk("R10 status_flag", {3'b0, status_flag}, {3'b0, v[1]});
      chk("R3 addr_err", {3'b0, addr_err}, {3'b0, v[0]});
      @(negedge clk);
      chk("R2 resp_valid one cycle", {3'b0, resp_valid}, 4'h0);
    end

    // R9: back-to-back on one digit
    @(negedge clk) drive(3'd2, 4'd5, 4'd5, 4'd0, 2'd0, 4'h0);
    @(negedge clk) drive(3'd4, 4'd5, 4'd5, 4'd0, 2'd3, 4'h0);
    @(negedge clk) drive(3'd1, 4'd5, 4'd5, 4'd0, 2'd0, 4'h0);
    @(negedge clk) op_req = 1'b0;
    chk("R9 bit set sees forwarded write", rd_data, 4'h0);
    @(negedge clk);
    chk("R9 read sees forwarded bit set", rd_data, 4'h8);

    // R9/R4: back-to-back register exchanges
    single(3'd2, 4'd9, 4'd4, 4'd0, 2'd0, 4'hC);
    @(negedge clk) drive(3'd3, 4'd0, 4'd0, 4'd4, 2'd0, 4'h2);
    @(negedge clk) drive(3'd3, 4'd0, 4'd0, 4'd4, 2'd0, 4'h7);
    @(negedge clk) op_req = 1'b0;
    chk("R4 first exchange old value", acc_out, 4'hC);
    @(negedge clk);
    chk("R9 second exchange sees first", acc_out, 4'h2);
    single(3'd1, 4'd9, 4'd4, 4'd0, 2'd0, 4'h0);
    chk("R4 indexed view of register 4", rd_data, 4'h7);

    // R3: rejected write left memory intact, R8 test leaves memory
    single(3'd2, 4'd15, 4'd5, 4'd0, 2'd0, 4'h3);
    chk("R3 error on x=15", {3'b0, addr_err}, 4'h1);
    single(3'd6, 4'd5, 4'd5, 4'd0, 2'd0, 4'h0);
    chk("R8 test bit0 of 8", {3'b0, status_flag}, 4'h0);
    single(3'd1, 4'd5, 4'd5, 4'd0, 2'd0, 4'h0);
    chk("R8 test left digit", rd_data, 4'h8);
    chk("R11 error cleared", {3'b0, addr_err}, 4'h0);

    // R1: mid-run reset clears flag
    single(3'd6, 4'd5, 4'd5, 4'd0, 2'd3, 4'h0);
    chk("R8 test bit3 of 8", {3'b0, status_flag}, 4'h1);
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    chk("R1 flag after reset", {3'b0, status_flag}, 4'h0);
    chk("R1 rd_data after reset", rd_data, 4'h0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule